// File: doc/BRIEF.md
# Two-Cycle Memory Command Sequencer

This block is the command side of a controller for a fast-cycle DRAM. In that DRAM every access is a fixed pair of command cycles, and each access closes its row by itself, so there is no separate activate or precharge. The first cycle selects the operation and carries the bank and the upper (row) address. The second cycle follows on the very next clock, and what it means depends on the first cycle: a lower-address latch with the column address, an auto-refresh, or a mode register set. Requests enter on a valid/ready handshake. The sequencer places each pair on registered pins. It holds back a request until every minimum spacing allows it: within a bank, across banks, between reads and writes, and after a refresh.

Besides the command pins, the block produces read and write strobe-enable windows for a separate datapath. These are timed from each lower-address latch by the CAS latency, and by the CAS latency minus one for writes. They are one or two cycles wide depending on the burst length. The block decodes mode-set requests aimed at the regular register to learn the burst length and burst order. It rejects codes that are not usable. An internal interval counter schedules auto-refreshes, and these take priority over waiting requests.

Top module: `pair_cmd_seq`

## Requirements
- R1: A read request (req_op 00) puts mem_cs_n=0, mem_fn=1 on the pins, and a write request (req_op 01) puts mem_cs_n=0, mem_fn=0. Both carry mem_ba=req_bank and mem_a=req_row. The command appears in the cycle after the accepting clock edge.
- R2: The cycle after any first command always carries its second command. For a read or write this is a lower-address latch: mem_cs_n=1 and mem_a holding req_col in its low bits with zeros above. No request is accepted while a first command is on the pins.
- R3: A refresh is issued as mem_cs_n=0, mem_fn=0 followed by mem_cs_n=0. A mode set (req_op 1x) is issued as mem_cs_n=0, mem_fn=1 with ba and a at zero, followed by mem_cs_n=0 with mem_ba={0,req_bank[1:0]} and mem_a=req_row.
- R4: Two first commands to the same bank are at least T_RC (6) cycles apart. A second read or write to the same bank waiting behind the first is issued exactly 6 cycles after it.
- R5: First commands to different banks are at least T_RBD (2) cycles apart. A read to another bank can follow a write so that it starts T_WRD (1) cycle after the write's second cycle, which gives a first-to-first distance of 2.
- R6: A write that follows a read is held until its first command is 2 cycles after the read's first command with burst length 2, and 3 cycles after it with burst length 4.
- R7: rd_strobe_en is high for BL/2 cycles, starting CL (5) cycles after the read's lower-address latch. wr_strobe_en does the same starting CL-1 (4) cycles after the write's latch. Both are low at all other times.
- R8: A mode set with req_bank[1:0]=00 is decoded from req_row. Bits [2:0] give the burst length: 001 means 2 and 010 means 4. Bit 3 gives the burst order: 1 means interleave. Bits [6:4] must equal 101, which is CL 5. Bit 7 must be 0. A valid code updates cfg_bl4 and cfg_interleave from the cycle after acceptance. After reset the block is in burst length 2, sequential order.
- R9: A mode set with a reserved length or latency code, with bit 7 set, or with req_bank[1:0]=1x is accepted but not issued. mode_err is high for the one cycle after acceptance, the pins show no command, and cfg_bl4 and cfg_interleave keep their values.
- R10: A mode set with req_bank[1:0]=01 (the extended register) is passed to the pins unchanged and leaves cfg_bl4 and cfg_interleave as they were.
- R11: A refresh falls due every REFI cycles. While one is due, req_ready is low, and the refresh is issued once all banks and strobe windows are idle.
- R12: After a refresh's second cycle, no first command is issued for T_REFC (22) cycles. A request that is waiting goes out exactly T_REFC cycles after that second cycle.
- R13: In reset, mem_cs_n is 1, both strobe enables and mode_err are 0, and cfg_bl4 and cfg_interleave are 0. req_ready is high after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_op | input | 2 | 00 read, 01 write, 1x mode set |
| req_bank | input | 3 | Bank; for a mode set, bits [1:0] select the register |
| req_row | input | AW | Upper address, or mode opcode |
| req_col | input | CW | Lower address |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_fn | output | 1 | Function select of the first command cycle |
| mem_ba | output | 3 | Bank address pins |
| mem_a | output | AW | Address pins |
| rd_strobe_en | output | 1 | Read data window for the datapath |
| wr_strobe_en | output | 1 | Write data window for the datapath |
| cfg_bl4 | output | 1 | 1 when the burst length is 4 |
| cfg_interleave | output | 1 | 1 when the burst order is interleaved |
| mode_err | output | 1 | One-cycle pulse on a rejected mode set |

## Verification
The bench builds the block with every timing parameter at its default and shortens REFI to 400 cycles. This brings two refresh intervals into a run of under a thousand cycles, so a stream of reads can be shown to be interrupted by refreshes exactly twice. The default spacings keep the 6-cycle same-bank gap, the 3-cycle read-to-write gap at burst length 4 and the 22-cycle refresh busy time measurable as exact cycle distances. A pin monitor checks the spacing rules on every first command as well.

// File: rtl/pair_cmd_seq.sv
module pair_cmd_seq #(
  parameter int AW        = 14,
  parameter int CW        = 9,
  parameter int T_RC      = 6,
  parameter int T_RBD     = 2,
  parameter int T_WRD     = 1,
  parameter int T_RWD_BL2 = 2,
  parameter int T_RWD_BL4 = 3,
  parameter int T_REFC    = 22,
  parameter int CL        = 5,
  parameter int REFI      = 1000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic [2:0]    req_bank,
  input  logic [AW-1:0] req_row,
  input  logic [CW-1:0] req_col,
  output logic          mem_cs_n,
  output logic          mem_fn,
  output logic [2:0]    mem_ba,
  output logic [AW-1:0] mem_a,
  output logic          rd_strobe_en,
  output logic          wr_strobe_en,
  output logic          cfg_bl4,
  output logic          cfg_interleave,
  output logic          mode_err
);
  localparam int NB      = 8;
  localparam int WL      = CL - 1;
  localparam int G_RR    = T_RBD;
  localparam int G_RW    = (T_WRD + 1 > T_RBD) ? T_WRD + 1 : T_RBD;
  localparam int G_WR2   = (T_RWD_BL2 > T_RBD) ? T_RWD_BL2 : T_RBD;
  localparam int G_WR4   = (T_RWD_BL4 > T_RBD) ? T_RWD_BL4 : T_RBD;
  localparam int TMAX    = T_REFC + T_RC + G_WR4 + G_RW;
  localparam int TW      = $clog2(TMAX + 1);
  localparam int RW      = $clog2(REFI);

  logic          phase2, p2_cs_n, p2_rd, p2_wr, p2_ref;
  logic [2:0]    p2_ba;
  logic [AW-1:0] p2_a;
  logic [TW-1:0] bank_tmr [NB];
  logic [TW-1:0] tmr_rd, tmr_wr, tmr_ref;
  logic [RW-1:0] ref_cnt;
  logic          ref_pend;
  logic [CL:0]   rd_st;
  logic [CL+1:0] rd_ex;
  logic [WL:0]   wr_st;
  logic [WL+1:0] wr_ex;
  logic          banks_idle, quiet, ref_go, acc;
  logic          is_rd, is_wr, is_ms, ms_valid, ms_pass, ms_bad;

  assign is_rd    = (req_op == 2'b00);
  assign is_wr    = (req_op == 2'b01);
  assign is_ms    = req_op[1];
  assign ms_valid = (req_bank[1:0] == 2'b00) && (req_row[2:0] == 3'b001 || req_row[2:0] == 3'b010)
                    && (req_row[6:4] == 3'(CL)) && !req_row[7];
  assign ms_pass  = (req_bank[1:0] == 2'b01);
  assign ms_bad   = !(ms_valid || ms_pass);

  always_comb begin
    banks_idle = 1'b1;
    for (int b = 0; b < NB; b++) if (bank_tmr[b] != '0) banks_idle = 1'b0;
  end

  assign quiet  = banks_idle && !(|{rd_st, rd_ex, wr_st, wr_ex}) && tmr_rd == '0 && tmr_wr == '0;
  assign ref_go = !phase2 && ref_pend && tmr_ref == '0 && quiet;
  assign req_ready = !phase2 && !ref_pend && tmr_ref == '0 &&
                     (is_ms ? quiet : (bank_tmr[req_bank] == '0 && (is_rd ? tmr_rd == '0 : tmr_wr == '0)));
  assign acc = req_valid && req_ready;

  assign rd_strobe_en = rd_st[CL] | rd_ex[CL+1];
  assign wr_strobe_en = wr_st[WL] | wr_ex[WL+1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_cs_n <= 1'b1; mem_fn <= 1'b0; mem_ba <= '0; mem_a <= '0;
      phase2 <= 1'b0; p2_cs_n <= 1'b1; p2_rd <= 1'b0; p2_wr <= 1'b0; p2_ref <= 1'b0;
      p2_ba <= '0; p2_a <= '0;
      for (int b = 0; b < NB; b++) bank_tmr[b] <= '0;
      tmr_rd <= '0; tmr_wr <= '0; tmr_ref <= '0;
      ref_cnt <= '0; ref_pend <= 1'b0;
      rd_st <= '0; rd_ex <= '0; wr_st <= '0; wr_ex <= '0;
      cfg_bl4 <= 1'b0; cfg_interleave <= 1'b0; mode_err <= 1'b0;
    end else begin
      mem_cs_n <= 1'b1; mem_fn <= 1'b0; mem_ba <= '0; mem_a <= '0;
      mode_err <= 1'b0;
      phase2   <= 1'b0;
      for (int b = 0; b < NB; b++) if (bank_tmr[b] != '0) bank_tmr[b] <= bank_tmr[b] - 1'b1;
      if (tmr_rd  != '0) tmr_rd  <= tmr_rd  - 1'b1;
      if (tmr_wr  != '0) tmr_wr  <= tmr_wr  - 1'b1;
      if (tmr_ref != '0) tmr_ref <= tmr_ref - 1'b1;
      rd_st <= {rd_st[CL-1:0], phase2 & p2_rd};
      rd_ex <= {rd_ex[CL:0],   phase2 & p2_rd & cfg_bl4};
      wr_st <= {wr_st[WL-1:0], phase2 & p2_wr};
      wr_ex <= {wr_ex[WL:0],   phase2 & p2_wr & cfg_bl4};

      if (phase2) begin
        mem_cs_n <= p2_cs_n; mem_ba <= p2_ba; mem_a <= p2_a;
        if (p2_ref) tmr_ref <= TW'(T_REFC - 1);
      end else if (ref_go) begin
        mem_cs_n <= 1'b0; phase2 <= 1'b1; ref_pend <= 1'b0;
        p2_cs_n <= 1'b0; p2_ba <= '0; p2_a <= '0;
        p2_rd <= 1'b0; p2_wr <= 1'b0; p2_ref <= 1'b1;
      end else if (acc) begin
        if (is_ms && ms_bad) begin
          mode_err <= 1'b1;
        end else begin
          phase2   <= 1'b1;
          mem_cs_n <= 1'b0;
          mem_fn   <= !is_wr;
          mem_ba   <= is_ms ? 3'b000 : req_bank;
          mem_a    <= is_ms ? '0 : req_row;
          p2_cs_n  <= !is_ms;
          p2_ba    <= is_ms ? {1'b0, req_bank[1:0]} : 3'b000;
          p2_a     <= is_ms ? req_row : {{(AW-CW){1'b0}}, req_col};
          p2_rd    <= is_rd; p2_wr <= is_wr; p2_ref <= 1'b0;
          if (!is_ms) begin
            bank_tmr[req_bank] <= TW'(T_RC - 1);
            tmr_rd <= is_rd ? TW'(G_RR - 1) : TW'(G_RW - 1);
            tmr_wr <= is_rd ? (cfg_bl4 ? TW'(G_WR4 - 1) : TW'(G_WR2 - 1)) : TW'(G_RR - 1);
          end else if (ms_valid) begin
            cfg_bl4        <= (req_row[2:0] == 3'b010);
            cfg_interleave <= req_row[3];
          end
        end
      end

      if (ref_cnt == RW'(REFI - 1)) begin
        ref_cnt  <= '0;
        ref_pend <= 1'b1;
      end else begin
        ref_cnt <= ref_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pair_cmd_seq_chk.sv
module pair_cmd_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic phase2,
  input logic ref_pend,
  input logic ref_busy,
  input logic req_ready,
  input logic mem_cs_n,
  input logic rd_strobe_en,
  input logic wr_strobe_en,
  input logic cfg_bl4,
  input logic cfg_interleave,
  input logic mode_err
);
  a_r1_first_on_pins: assert property (@(posedge clk) disable iff (!rst_n)
    phase2 |-> !mem_cs_n);
  a_r2_second_next: assert property (@(posedge clk) disable iff (!rst_n)
    phase2 |=> !phase2);
  a_r2_no_accept_mid_pair: assert property (@(posedge clk) disable iff (!rst_n)
    phase2 |-> !req_ready);
  a_r11_refresh_first: assert property (@(posedge clk) disable iff (!rst_n)
    ref_pend |-> !req_ready);
  a_r12_refresh_busy: assert property (@(posedge clk) disable iff (!rst_n)
    ref_busy |-> !req_ready);
  a_r7_windows_apart: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_strobe_en && wr_strobe_en));
  a_r9_err_no_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    mode_err |-> mem_cs_n);
  a_r9_err_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mode_err |-> ($stable(cfg_bl4) && $stable(cfg_interleave)));
endmodule

bind pair_cmd_seq pair_cmd_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .phase2(phase2), .ref_pend(ref_pend),
  .ref_busy(tmr_ref != '0), .req_ready(req_ready), .mem_cs_n(mem_cs_n),
  .rd_strobe_en(rd_strobe_en), .wr_strobe_en(wr_strobe_en),
  .cfg_bl4(cfg_bl4), .cfg_interleave(cfg_interleave), .mode_err(mode_err)
);

// File: tb/pair_cmd_seq_tb.sv
`timescale 1ns/1ps
module pair_cmd_seq_tb;
  localparam int AW = 14, CW = 9, REFI = 400, T_RC = 6, T_REFC = 22, CL = 5;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_ready;
  logic [1:0] req_op = 0;
  logic [2:0] req_bank = 0;
  logic [AW-1:0] req_row = 0;
  logic [CW-1:0] req_col = 0;
  logic mem_cs_n, mem_fn, rd_strobe_en, wr_strobe_en, cfg_bl4, cfg_interleave, mode_err;
  logic [2:0] mem_ba;
  logic [AW-1:0] mem_a;

  pair_cmd_seq #(.AW(AW), .CW(CW), .REFI(REFI)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
    .mem_cs_n(mem_cs_n), .mem_fn(mem_fn), .mem_ba(mem_ba), .mem_a(mem_a),
    .rd_strobe_en(rd_strobe_en), .wr_strobe_en(wr_strobe_en),
    .cfg_bl4(cfg_bl4), .cfg_interleave(cfg_interleave), .mode_err(mode_err));

  always #5 clk = ~clk;

  int cyc = 0, checks = 0, failures = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // pin monitor
  bit mon_second = 0, mon_fn = 0, need_gap = 0;
  logic [2:0] mon_ba = 0;
  int last_first = -100, ref_end = -1000, ref_cnt = 0, post_ref_gap = -1;
  int last_bank [8] = '{default: -100};
  always @(negedge clk) if (rst_n) begin
    if (mon_second) begin
      mon_second = 0;
      if (mem_cs_n) begin
        chk(cyc - 1 - last_bank[mon_ba] >= T_RC, "R4", cyc - 1 - last_bank[mon_ba], T_RC);
        last_bank[mon_ba] = cyc - 1;
      end else if (!mon_fn) begin
        ref_cnt++; ref_end = cyc; need_gap = 1;
      end
    end else if (!mem_cs_n) begin
      mon_second = 1; mon_fn = mem_fn; mon_ba = mem_ba;
      chk(cyc - last_first >= 2, "R5", cyc - last_first, 2);
      last_first = cyc;
      if (need_gap) begin
        need_gap = 0; post_ref_gap = cyc - ref_end;
        chk(post_ref_gap >= T_REFC, "R12", post_ref_gap, T_REFC);
      end
    end
  end

  task automatic issue(input logic [1:0] op, input logic [2:0] bank,
                       input logic [AW-1:0] row, input logic [CW-1:0] col, output int acc);
    req_valid = 1; req_op = op; req_bank = bank; req_row = row; req_col = col;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    acc = cyc;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic at_cycle(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  // {op, bank, row, col, expected first-to-first gap (0 = none)}
  localparam logic [32:0] TAB [9] = '{
    {2'b00, 3'd0, 14'h1A5C, 9'h013, 5'd0},
    {2'b00, 3'd1, 14'h0F0F, 9'h1FF, 5'd2},
    {2'b01, 3'd2, 14'h3FFF, 9'h000, 5'd2},
    {2'b00, 3'd3, 14'h2222, 9'h0AA, 5'd2},
    {2'b01, 3'd3, 14'h1111, 9'h155, 5'd6},
    {2'b01, 3'd5, 14'h0001, 9'h101, 5'd2},
    {2'b00, 3'd5, 14'h2A2A, 9'h0F0, 5'd6},
    {2'b00, 3'd6, 14'h1357, 9'h077, 5'd2},
    {2'b00, 3'd6, 14'h0246, 9'h188, 5'd6}
  };

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int acc, prev, a2;
    logic [1:0] prev_op;
    repeat (3) @(posedge clk);
    chk(mem_cs_n == 1 && rd_strobe_en == 0 && wr_strobe_en == 0, "R13", mem_cs_n, 1);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    chk(mem_cs_n == 1, "R13", mem_cs_n, 1);
    chk(cfg_bl4 == 0 && cfg_interleave == 0 && mode_err == 0, "R13", {cfg_bl4, cfg_interleave, mode_err}, 0);
    chk(req_ready == 1, "R13", req_ready, 1);

    prev = 0; prev_op = 0;
    for (int i = 0; i < 9; i++) begin
      logic [1:0] op; logic [2:0] bk; logic [AW-1:0] rw; logic [CW-1:0] cl; int gp;
      {op, bk, rw, cl} = TAB[i][32:5]; gp = int'(TAB[i][4:0]);
      issue(op, bk, rw, cl, acc);
      if (gp != 0) begin
        if (gp == T_RC) chk(acc - prev == gp, "R4", acc - prev, gp);
        else if (op == 2'b01 && prev_op == 2'b00) chk(acc - prev == gp, "R6", acc - prev, gp);
        else chk(acc - prev == gp, "R5", acc - prev, gp);
      end
      prev = acc; prev_op = op;
      chk(mem_cs_n == 0 && mem_fn == (op == 2'b00), "R1", {mem_cs_n, mem_fn}, {1'b0, op == 2'b00});
      chk(mem_ba == bk && mem_a == rw, "R1", mem_a, rw);
      @(negedge clk);
      chk(mem_cs_n == 1 && mem_a == {{(AW-CW){1'b0}}, cl}, "R2", mem_a, cl);
    end

    // read and write windows, burst length 2
    at_cycle(cyc + 10);
    issue(2'b00, 3'd7, 14'h0100, 9'h001, acc);
    at_cycle(acc + 6); chk(rd_strobe_en == 0, "R7", rd_strobe_en, 0);
    at_cycle(acc + 7); chk(rd_strobe_en == 1, "R7", rd_strobe_en, 1);
    at_cycle(acc + 8); chk(rd_strobe_en == 0, "R7", rd_strobe_en, 0);
    issue(2'b01, 3'd7, 14'h0101, 9'h002, acc);
    at_cycle(acc + 5); chk(wr_strobe_en == 0, "R7", wr_strobe_en, 0);
    at_cycle(acc + 6); chk(wr_strobe_en == 1, "R7", wr_strobe_en, 1);
    at_cycle(acc + 7); chk(wr_strobe_en == 0, "R7", wr_strobe_en, 0);

    // rejected mode sets: bad length, bad latency, test bit, reserved select
    issue(2'b10, 3'd0, 14'h0053, 9'h0, acc);
    chk(mode_err == 1 && mem_cs_n == 1 && cfg_bl4 == 0, "R9", mode_err, 1);
    issue(2'b10, 3'd0, 14'h0042, 9'h0, acc);
    chk(mode_err == 1 && mem_cs_n == 1, "R9", mode_err, 1);
    issue(2'b10, 3'd0, 14'h00D2, 9'h0, acc);
    chk(mode_err == 1 && mem_cs_n == 1 && cfg_bl4 == 0, "R9", mode_err, 1);
    issue(2'b11, 3'd2, 14'h005A, 9'h0, acc);
    chk(mode_err == 1 && cfg_interleave == 0 && cfg_bl4 == 0, "R9", {cfg_bl4, cfg_interleave}, 0);
    @(negedge clk);
    chk(mode_err == 0 && mem_cs_n == 1, "R9", mode_err, 0);

    // extended register passes through
    issue(2'b10, 3'd1, 14'h1234, 9'h0, acc);
    chk(mem_cs_n == 0 && mem_fn == 1 && mem_ba == 0 && mem_a == 0, "R3", mem_a, 0);
    chk(mode_err == 0, "R10", mode_err, 0);
    @(negedge clk);
    chk(mem_cs_n == 0 && mem_ba == 3'd1 && mem_a == 14'h1234, "R10", mem_a, 14'h1234);
    chk(cfg_bl4 == 0 && cfg_interleave == 0, "R10", {cfg_bl4, cfg_interleave}, 0);

    // regular register: length 4, interleave, latency 5
    issue(2'b10, 3'd0, 14'h005A, 9'h0, acc);
    chk(cfg_bl4 == 1 && cfg_interleave == 1 && mode_err == 0, "R8", {cfg_bl4, cfg_interleave}, 3);
    @(negedge clk);
    chk(mem_cs_n == 0 && mem_ba == 0 && mem_a == 14'h005A, "R3", mem_a, 14'h005A);

    // burst length 4 spacings
    issue(2'b00, 3'd0, 14'h0300, 9'h010, prev);
    @(negedge clk);
    issue(2'b01, 3'd1, 14'h0301, 9'h011, acc);
    chk(acc - prev == 3, "R6", acc - prev, 3);
    @(negedge clk);
    issue(2'b01, 3'd2, 14'h0302, 9'h012, prev);
    @(negedge clk);
    issue(2'b00, 3'd3, 14'h0303, 9'h013, acc);
    chk(acc - prev == 2, "R5", acc - prev, 2);

    // burst length 4 read window
    at_cycle(cyc + 12);
    issue(2'b00, 3'd4, 14'h0400, 9'h020, acc);
    at_cycle(acc + 6); chk(rd_strobe_en == 0, "R7", rd_strobe_en, 0);
    at_cycle(acc + 7); chk(rd_strobe_en == 1, "R7", rd_strobe_en, 1);
    at_cycle(acc + 8); chk(rd_strobe_en == 1, "R7", rd_strobe_en, 1);
    at_cycle(acc + 9); chk(rd_strobe_en == 0, "R7", rd_strobe_en, 0);

    // continuous reads across two refresh intervals
    chk(ref_cnt == 0, "R11", ref_cnt, 0);
    a2 = 0;
    while (cyc < 2 * REFI + 50) begin
      issue(2'b00, 3'(a2 % 8), 14'(a2), 9'(a2), acc);
      @(negedge clk);
      a2++;
    end
    chk(ref_cnt == 2, "R11", ref_cnt, 2);
    chk(post_ref_gap == T_REFC, "R12", post_ref_gap, T_REFC);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule